// File: doc/BRIEF.md
# Scrambled Line Decoder with Sticky Integrity Flag

This block sits at the receive end of a serial link whose transmitter scrambles each payload word with a pair of registers. The registers follow an additive Fibonacci recurrence with end-around carry. Every transmitted symbol is `W+2` bits wide. Its two upper bits are a prefix formed by a half adder from the generator's carry and the top bit of one register, so data symbols never carry the prefix `11`. The lower `W` bits are the scrambled payload. The prefix `11` is reserved as a packet-start marker. When the decoder sees it, it re-seeds its local generator with the constants the transmitter also uses.

For each data symbol the decoder undoes the scrambling to recover the payload and advances its generator with the recovered word. It also works out which prefix a healthy channel would have delivered and compares that with the prefix it received. The integrity flag is set by a start marker and clears at the first disagreement. It then stays clear until the next start marker. A corrupted payload bit alters the generator state, so it shows up as a prefix mismatch one or more words later. For this reason a packet is closed with two padding words.

Top module: `line_descrambler`

## Requirements
- R1: A valid symbol whose bits `[W+1:W]` equal `11` is a start marker. It loads X=INIT_X, Y=INIT_Y and carry C=0, sets `ok_o` to 1 and raises `start_o` for one cycle. It produces no payload, and the content of its bits `[W-1:0]` has no effect.
- R2: After reset all outputs are 0. Until the first start marker, data symbols produce no `pay_valid_o`, and `ok_o` stays 0.
- R3: For a data symbol with payload field S (bits `[W-1:0]`), the recovered word is `((S XOR X) + D) mod 2^W`, where D = Y[W-1]. A back-to-back transmitter therefore gets its payload words back unchanged.
- R4: Each valid data symbol received after a start marker advances the generator exactly once. The update is T = X + Y + C, then X' = T mod 2^W, C' = bit W of T, and Y' = (X + recovered word) mod 2^W. Idle cycles leave the state unchanged.
- R5: The expected prefix is `{C AND D, C XOR D}`. `ok_o` stays 1 while every received prefix equals it.
- R6: On the word whose received prefix differs from the expected one, `ok_o` reads 0 together with that word's `pay_valid_o`. It then remains 0 until the next start marker.
- R7: Flipping only bit W-1 of a payload field, with the prefix left intact, clears `ok_o` no later than the word after it. This holds even when that following word is padding.
- R8: `pay_valid_o` and `start_o` rise two clock edges after the edge that samples the corresponding `sym_valid_i`.
- R9: `pay_valid_o` and `start_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sym_valid_i | input | 1 | Symbol present this cycle |
| sym_i | input | W+2 | Received symbol: prefix in `[W+1:W]`, scrambled payload in `[W-1:0]` |
| pay_o | output | W | Recovered payload word |
| pay_valid_o | output | 1 | `pay_o` holds a new word |
| ok_o | output | 1 | Sticky integrity flag |
| start_o | output | 1 | One-cycle pulse per start marker |

## Verification
The bench builds the block with W=16 and non-trivial seed constants. This lets a transmitter model drive real 18-bit symbols and reproduce exact carry and top-bit behaviour. Clean packets with idle gaps, a flip in the top payload bit and a flip in the prefix all fit in a few hundred cycles. A second model of the decoder predicts the exact word on which the flag falls. Start markers with arbitrary payload fields, and data sent before any marker, cover the re-seed and unarmed cases.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  localparam logic [1:0] PFX_START = 2'b11;

  // half adder of carry and register top bit: {and, xor}; never yields 11
  function automatic logic [1:0] pfx_of(input logic carry, input logic top);
    return {carry & top, carry ^ top};
  endfunction

endpackage

// File: rtl/lsd_in_stage.sv
module lsd_in_stage #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W+1:0] sym_i,
  output logic         valid_o,
  output logic         start_o,
  output logic [1:0]   pfx_o,
  output logic [W-1:0] field_o
);
  import lsd_pkg::*;

  logic         valid_d, start_d;
  logic [1:0]   pfx_d;
  logic [W-1:0] field_d;

  always_comb begin
    valid_d = valid_i;
    start_d = valid_i && (sym_i[W+1:W] == PFX_START);
    pfx_d   = pfx_o;
    field_d = field_o;
    if (valid_i) begin
      pfx_d   = sym_i[W+1:W];
      field_d = sym_i[W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      start_o <= 1'b0;
      pfx_o   <= '0;
      field_o <= '0;
    end else begin
      valid_o <= valid_d;
      start_o <= start_d;
      pfx_o   <= pfx_d;
      field_o <= field_d;
    end
  end

  AST_START_IS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> valid_o) else $error("start without valid"); // R1

endmodule

// File: rtl/lsd_gen_core.sv
module lsd_gen_core #(
  parameter int         W      = 16,
  parameter logic [W-1:0] INIT_X = 16'h5A3C,
  parameter logic [W-1:0] INIT_Y = 16'hC3A5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         seed_i,
  input  logic         step_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic         c_o,
  output logic         armed_o
);

  logic [W:0]   sum;
  logic [W-1:0] x_d, y_d;
  logic         c_d, armed_d;

  always_comb begin
    sum     = {1'b0, x_o} + {1'b0, y_o} + {{W{1'b0}}, c_o};
    x_d     = x_o;
    y_d     = y_o;
    c_d     = c_o;
    armed_d = armed_o;
    if (seed_i) begin
      x_d     = INIT_X;
      y_d     = INIT_Y;
      c_d     = 1'b0;
      armed_d = 1'b1;
    end else if (step_i) begin
      x_d = sum[W-1:0];
      c_d = sum[W];
      y_d = x_o + word_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o     <= '0;
      y_o     <= '0;
      c_o     <= 1'b0;
      armed_o <= 1'b0;
    end else begin
      x_o     <= x_d;
      y_o     <= y_d;
      c_o     <= c_d;
      armed_o <= armed_d;
    end
  end

  AST_STEP_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> armed_o) else $error("step while unarmed"); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !seed_i) |=> ($stable(x_o) && $stable(y_o) && $stable(c_o))) else $error("state moved while idle"); // R4

endmodule

// File: rtl/lsd_recover.sv
module lsd_recover #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c_i,
  input  logic [W-1:0] field_i,
  input  logic [1:0]   pfx_i,
  output logic [W-1:0] word_o,
  output logic         match_o
);
  import lsd_pkg::*;

  logic       dbit;
  logic [1:0] expect_pfx;

  always_comb begin
    dbit       = y_i[W-1];
    expect_pfx = pfx_of(c_i, dbit);
    word_o     = (field_i ^ x_i) + {{(W-1){1'b0}}, dbit};
    match_o    = (expect_pfx == pfx_i);
  end

endmodule

// File: rtl/line_descrambler.sv
module line_descrambler #(
  parameter int           W      = 16,
  parameter logic [W-1:0] INIT_X = 16'h5A3C,
  parameter logic [W-1:0] INIT_Y = 16'hC3A5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sym_valid_i,
  input  logic [W+1:0] sym_i,
  output logic [W-1:0] pay_o,
  output logic         pay_valid_o,
  output logic         ok_o,
  output logic         start_o
);
  import lsd_pkg::*;

  logic rst_s1, rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1 <= 1'b0;
      rst_n  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_n  <= rst_s1;
    end
  end

  logic         s1_valid, s1_start;
  logic [1:0]   s1_pfx;
  logic [W-1:0] s1_field;

  lsd_in_stage #(.W(W)) in_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .valid_i (sym_valid_i),
    .sym_i   (sym_i),
    .valid_o (s1_valid),
    .start_o (s1_start),
    .pfx_o   (s1_pfx),
    .field_o (s1_field)
  );

  logic         seed, step, armed, gc;
  logic [W-1:0] gx, gy, word;
  logic         match;

  assign seed = s1_valid && s1_start;
  assign step = s1_valid && !s1_start && armed;

  lsd_recover #(.W(W)) rec_i (
    .x_i     (gx),
    .y_i     (gy),
    .c_i     (gc),
    .field_i (s1_field),
    .pfx_i   (s1_pfx),
    .word_o  (word),
    .match_o (match)
  );

  lsd_gen_core #(.W(W), .INIT_X(INIT_X), .INIT_Y(INIT_Y)) gen_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .seed_i  (seed),
    .step_i  (step),
    .word_i  (word),
    .x_o     (gx),
    .y_o     (gy),
    .c_o     (gc),
    .armed_o (armed)
  );

  logic [W-1:0] pay_d;
  logic         pv_d, ok_d, st_d;

  always_comb begin
    pay_d = pay_o;
    pv_d  = step;
    st_d  = seed;
    ok_d  = ok_o;
    if (seed) begin
      ok_d = 1'b1;
    end else if (step) begin
      pay_d = word;
      ok_d  = ok_o & match;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      pay_o       <= '0;
      pay_valid_o <= 1'b0;
      ok_o        <= 1'b0;
      start_o     <= 1'b0;
    end else begin
      pay_o       <= pay_d;
      pay_valid_o <= pv_d;
      ok_o        <= ok_d;
      start_o     <= st_d;
    end
  end

  AST_OK_RISES_ON_START: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(ok_o) |-> start_o) else $error("ok rose without start"); // R6
  AST_START_SETS_OK: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_o |-> ok_o) else $error("start left ok low"); // R1
  AST_START_FROM_MARKER: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_o |-> $past(sym_valid_i && (sym_i[W+1:W] == PFX_START), 2)) else $error("start without marker"); // R8
  AST_PAY_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_n)
    pay_valid_o |-> $past(sym_valid_i, 2)) else $error("payload latency"); // R8
  AST_PAY_START_EXCL: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(pay_valid_o && start_o)) else $error("payload and start together"); // R9

endmodule

// File: tb/line_descrambler_tb_top.sv
module line_descrambler_tb_top;
  localparam int W = 16;
  localparam logic [W-1:0] IX = 16'h5A3C;
  localparam logic [W-1:0] IY = 16'hC3A5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sym_valid = 1'b0;
  logic [W+1:0] sym = '0;
  logic [W-1:0] pay;
  logic         pay_valid, ok, start;

  always #4 clk = ~clk;

  line_descrambler #(.W(W), .INIT_X(IX), .INIT_Y(IY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(sym_valid), .sym_i(sym),
    .pay_o(pay), .pay_valid_o(pay_valid), .ok_o(ok), .start_o(start)
  );

  typedef struct { bit is_start; logic [W-1:0] word; bit okv; int cyc; } item_t;
  item_t exp_q[$];

  int checks = 0, fails = 0, cyc = 0;
  bit mon_on = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // generator step shared by both bench models: returns {x', y', c'}
  function automatic logic [2*W:0] nxt(logic [W-1:0] x, logic [W-1:0] y, logic c, logic [W-1:0] p);
    logic [W:0] t;
    t = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    return {t[W-1:0], x + p, t[W]};
  endfunction

  // transmitter model
  logic [W-1:0] ex, ey; logic ec;
  // receiver model
  logic [W-1:0] mx, my; logic mc, mok, marm = 0;
  bit dirty;

  function automatic logic [W+1:0] enc(logic [W-1:0] p);
    logic d; logic [1:0] pf; logic [W-1:0] s;
    d  = ey[W-1];
    pf = {ec & d, ec ^ d};
    s  = (p - {{(W-1){1'b0}}, d}) ^ ex;
    {ex, ey, ec} = nxt(ex, ey, ec, p);
    return {pf, s};
  endfunction

  task automatic send(input logic [W+1:0] s, input logic [W-1:0] orig);
    item_t it; logic d; logic [W-1:0] p;
    @(negedge clk);
    sym_valid = 1'b1; sym = s;
    if (s[W+1:W] == 2'b11) begin
      mx = IX; my = IY; mc = 1'b0; mok = 1'b1; marm = 1'b1; dirty = 0;
      it.is_start = 1; it.word = '0; it.okv = 1; it.cyc = cyc;
      exp_q.push_back(it);
    end else if (marm) begin
      d = my[W-1];
      p = (s[W-1:0] ^ mx) + {{(W-1){1'b0}}, d};
      mok = mok & ({mc & d, mc ^ d} == s[W+1:W]);
      {mx, my, mc} = nxt(mx, my, mc, p);
      it.is_start = 0; it.word = dirty ? p : orig; it.okv = mok; it.cyc = cyc;
      exp_q.push_back(it);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sym_valid = 1'b0; sym = '0;
    end
  endtask

  task automatic pkt_start(input logic [W-1:0] junk);
    ex = IX; ey = IY; ec = 1'b0;
    send({2'b11, junk}, '0);
  endtask

  task automatic data(input logic [W-1:0] p, input logic [W+1:0] flip);
    logic [W+1:0] s;
    s = enc(p);
    if (flip != '0) dirty = 1;
    send(s ^ flip, p);
  endtask

  task automatic drain;
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R8 drain", exp_q.size(), 0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_on && (pay_valid || start)) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected output", {pay_valid, start}, 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(start == e.is_start, "R9 kind", start, e.is_start);
        chk(cyc - e.cyc == 2, "R8 latency", cyc - e.cyc, 2);
        chk(ok == e.okv, "R6 ok flag", ok, e.okv);
        if (!e.is_start) chk(pay == e.word, "R3 payload", pay, e.word);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] lf;
    logic [W+1:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2 reset state
    chk(pay_valid == 0 && start == 0, "R2 reset strobes", {pay_valid, start}, 0);
    chk(ok == 0, "R2 reset ok", ok, 0);
    chk(pay == 0, "R2 reset payload", pay, 0);
    mon_on = 1;

    // R2 data before any start is dropped
    ex = IX; ey = IY; ec = 0;
    data(16'h1234, '0); data(16'hFFFF, '0); data(16'h0000, '0);
    idle(5);
    chk(ok == 0, "R2 ok before start", ok, 0);

    // R1 R3 R4 R5 clean packet with idle gaps, start field ignored
    pkt_start(16'hBEEF);
    data(16'h0000, '0); data(16'hFFFF, '0); idle(3);
    data(16'h8001, '0); data(16'h7FFE, '0); idle(1);
    data(16'hAAAA, '0); data(16'h5555, '0); data(16'h0001, '0);
    data(16'h0000, '0); data(16'h0000, '0);
    idle(2); drain();
    chk(ok == 1, "R5 ok after clean packet", ok, 1);

    // R7 top payload bit flipped, detected by padding; R6 sticky
    pkt_start(16'h0F0F);
    data(16'h1111, '0); data(16'h2222, '0); data(16'h3333, '0);
    data(16'h4444, 18'h08000);
    data(16'h0000, '0); data(16'h0000, '0);
    idle(2); drain();
    chk(ok == 0, "R7 payload-only error caught", ok, 0);
    data(16'h5555, '0); data(16'h6666, '0);
    idle(2); drain();
    chk(ok == 0, "R6 ok stays low", ok, 0);

    // R1 restart restores ok; R6 prefix flip seen on that word
    pkt_start(16'hFFFF);
    idle(2); drain();
    chk(ok == 1, "R1 start restores ok", ok, 1);
    data(16'hCAFE, '0);
    s = enc(16'hD00D);
    dirty = 1;
    if (s[W+1:W] == 2'b10) send(s ^ 18'h20000, 16'hD00D);
    else send(s ^ 18'h10000, 16'hD00D);
    data(16'h0000, '0); data(16'h0000, '0);
    idle(2); drain();
    chk(ok == 0, "R6 prefix error", ok, 0);

    // R3 R4 long clean packet, back-to-back starts
    pkt_start(16'h0000);
    pkt_start(16'h1357);
    lf = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      data(lf, '0);
      if (i % 7 == 3) idle(1);
    end
    data(16'h0000, '0); data(16'h0000, '0);
    idle(2); drain();
    chk(ok == 1, "R4 ok after long packet", ok, 1);

    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule